// File: doc/BRIEF.md
# Mode-Selectable 8 kHz Frame Timing Generator

This block produces the 125 µs frame timing that a master on a time-division multiplexed backplane drives. It runs from a 16.384 MHz system clock and counts 2048 clocks per frame. Each frame it emits a one-clock active-high frame pulse and the matching active-low frame-start strobe.

A 3-bit mode code does two things. It picks one of three external 8 kHz reference inputs, and it picks how the counter follows that reference. In tracking modes (1 to 3) the counter is never jumped. Instead, each frame is stretched or shortened by one clock so that the frame rate locks to the reference while the phase is left free. In aligning modes (5 to 7) every reference edge reloads the counter, so the frames are also phase-aligned to the reference.

The outputs are live only while the master-enable input is set and the mode code is one of the six valid codes. When no reference edge arrives for four frames in a row, the counter keeps running at the nominal length and a loss flag is raised.

Top module: `frame_timing_gen`

## Requirements
- R1: The mode code selects the reference input. Codes 1 and 5 use ref_i[0], codes 2 and 6 use ref_i[1], and codes 3 and 7 use ref_i[2]. Edges on the other two inputs have no effect on the outputs.
- R2: When master_en_i is 0, or mode_i[1:0] is 0 (codes 0 and 4), frame_o is 0, frame_n_o is 1, ref_lost_o is 0 and the frame counter is held at count 0. The first frame pulse comes in the same cycle that the block becomes enabled. The same output values hold during reset.
- R3: With no reference correction, a frame lasts 2048 clocks. frame_o is high for exactly one clock, at count 0. frame_n_o is always the inverse of frame_o.
- R4: Each reference input passes through two synchroniser flops, and a rising edge is a 0-to-1 change between consecutive synchronised samples. In an aligning mode, suppose the reference is first sampled high at clock edge k. Then frame_o is high in the cycle after clock edge k+2.
- R5: In aligning modes (mode_i[2] = 1), a detected edge of the selected reference reloads the counter to 0. The frame interval then equals the reference period.
- R6: In tracking modes (mode_i[2] = 0), the counter only counts up by one or wraps to 0. An edge seen at count 1 to 1023 makes the current frame 2049 clocks long. An edge seen at count 1024 or above makes it 2047 clocks long. An edge at count 0 leaves it at 2048. Each edge gives one adjustment, and every frame interval is 2047, 2048 or 2049 clocks.
- R7: After 4 consecutive frame wraps with no selected-reference edge, ref_lost_o rises and the counter keeps wrapping every 2048 clocks. The next selected-reference edge clears ref_lost_o on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16.384 MHz system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | Master enable; when 0 the outputs are held idle |
| mode_i | input | 3 | Bit 2 selects aligning (1) or tracking (0); bits 1:0 select the reference (0 = none) |
| ref_i | input | 3 | Three asynchronous 8 kHz reference inputs |
| frame_o | output | 1 | One-clock active-high frame pulse |
| frame_n_o | output | 1 | Active-low frame-start strobe |
| ref_lost_o | output | 1 | Selected reference missing for 4 frames |

## Verification
An aligning run uses a reference period shorter than the frame. A design that ignored the reload would show 2048-clock intervals, and one that mis-selected the input would follow a decoy reference running at another period. Tracking runs start with the reference edge in each half of the frame and expect intervals of 2047 to 2049. A design that jumped the counter, or that swapped the long and short corrections, would leave that band or walk away from the reference. A silent-reference stretch must raise the loss flag only after the fourth missed wrap and clear it on the first returning edge. Idle codes 0 and 4, and dropping the enable, must silence the outputs at once even while references keep toggling.

// File: rtl/frame_gen_pkg.sv
package frame_gen_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_LONG  = 2'd1,
    ADJ_SHORT = 2'd2
  } adj_e;

  typedef struct packed {
    logic       active;
    logic       align;
    logic [1:0] sel;
  } mode_dec_t;
endpackage

// File: rtl/fg_ref_edge.sv
module fg_ref_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SYNC_STAGES-1:0], ref_i};
  end

  assign rise_o = sr_q[SYNC_STAGES-1] & ~sr_q[SYNC_STAGES];
endmodule

// File: rtl/fg_mode_decode.sv
module fg_mode_decode
  import frame_gen_pkg::*;
#(
  parameter int NUM_REFS = 3
) (
  input  logic       master_en_i,
  input  logic [2:0] mode_i,
  output mode_dec_t  dec_o
);
  always_comb begin
    dec_o.align  = mode_i[2];
    dec_o.active = master_en_i && (mode_i[1:0] != 2'd0)
                   && (int'(mode_i[1:0]) <= NUM_REFS);
    dec_o.sel    = dec_o.active ? mode_i[1:0] - 2'd1 : 2'd0;
  end
endmodule

// File: rtl/fg_frame_counter.sv
module fg_frame_counter
  import frame_gen_pkg::*;
#(
  parameter int FRAME_CLKS  = 2048,
  parameter int LOST_FRAMES = 4,
  localparam int CW         = $clog2(FRAME_CLKS) + 1,
  localparam int MW         = $clog2(LOST_FRAMES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          align_i,
  input  logic          edge_i,
  output logic [CW-1:0] cnt_o,
  output logic          lost_o
);
  localparam logic [CW-1:0] NOM_TERM = CW'(FRAME_CLKS - 1);
  localparam logic [CW-1:0] HALF     = CW'(FRAME_CLKS / 2);
  localparam logic [MW-1:0] MISS_MAX = MW'(LOST_FRAMES);

  logic [CW-1:0] cnt_q, term;
  logic [MW-1:0] miss_q;
  adj_e          adj_q;
  logic          lost_q, wrap;

  always_comb begin
    unique case (adj_q)
      ADJ_LONG:  term = NOM_TERM + CW'(1);
      ADJ_SHORT: term = NOM_TERM - CW'(1);
      default:   term = NOM_TERM;
    endcase
    if (align_i) term = NOM_TERM;
  end

  // >= guards against a shortened term landing below the current count
  assign wrap = (cnt_q >= term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      adj_q  <= ADJ_NONE;
      miss_q <= '0;
      lost_q <= 1'b0;
    end else if (!active_i) begin
      cnt_q  <= '0;
      adj_q  <= ADJ_NONE;
      miss_q <= '0;
      lost_q <= 1'b0;
    end else begin
      if ((align_i && edge_i) || wrap) cnt_q <= '0;
      else                             cnt_q <= cnt_q + CW'(1);

      if (align_i)                 adj_q <= ADJ_NONE;
      else if (edge_i) begin
        if (cnt_q == '0)           adj_q <= ADJ_NONE;
        else if (cnt_q < HALF)     adj_q <= ADJ_LONG;
        else                       adj_q <= ADJ_SHORT;
      end else if (wrap)           adj_q <= ADJ_NONE;

      if (edge_i) begin
        miss_q <= '0;
        lost_q <= 1'b0;
      end else if (wrap) begin
        if (miss_q < MISS_MAX) miss_q <= miss_q + MW'(1);
        if (miss_q >= MISS_MAX - MW'(1)) lost_q <= 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign lost_o = lost_q;
endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
  import frame_gen_pkg::*;
#(
  parameter int FRAME_CLKS  = 2048,
  parameter int LOST_FRAMES = 4,
  parameter int NUM_REFS    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FRAME_CLKS) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                master_en_i,
  input  logic [2:0]          mode_i,
  input  logic [NUM_REFS-1:0] ref_i,
  output logic                frame_o,
  output logic                frame_n_o,
  output logic                ref_lost_o
);
  mode_dec_t           dec;
  logic [NUM_REFS-1:0] rise;
  logic                sel_edge;
  logic [CNT_W-1:0]    cnt_q;
  logic                lost_q;

  fg_mode_decode #(.NUM_REFS(NUM_REFS)) u_dec (
    .master_en_i(master_en_i),
    .mode_i     (mode_i),
    .dec_o      (dec)
  );

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
    fg_ref_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ref_i (ref_i[i]),
      .rise_o(rise[i])
    );
  end

  assign sel_edge = dec.active && rise[dec.sel];

  fg_frame_counter #(
    .FRAME_CLKS (FRAME_CLKS),
    .LOST_FRAMES(LOST_FRAMES)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(dec.active),
    .align_i (dec.align),
    .edge_i  (sel_edge),
    .cnt_o   (cnt_q),
    .lost_o  (lost_q)
  );

  assign frame_o    = dec.active && (cnt_q == '0);
  assign frame_n_o  = ~frame_o;
  assign ref_lost_o = dec.active && lost_q;
endmodule

// File: rtl/frame_gen_checker.sv
module frame_gen_checker #(
  parameter int CW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          master_en_i,
  input logic [2:0]    mode_i,
  input logic          frame_o,
  input logic          frame_n_o,
  input logic          ref_lost_o,
  input logic          sel_edge,
  input logic [CW-1:0] cnt
);
  logic act;
  assign act = master_en_i && (mode_i[1:0] != 2'd0);

  a_r3_strobe_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_n_o == !frame_o);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |-> (!frame_o && !ref_lost_o));

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && !(sel_edge && mode_i[2])) |=> !frame_o);

  a_r5_align_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && mode_i[2] && sel_edge) |=> (frame_o || !master_en_i || mode_i[1:0] == 2'd0));

  a_r7_lost_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && sel_edge) |=> !ref_lost_o);

  a_r6_no_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != '0) |-> ($past(act) && cnt == $past(cnt) + CW'(1)));
endmodule

bind frame_timing_gen frame_gen_checker #(.CW(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .master_en_i(master_en_i),
  .mode_i     (mode_i),
  .frame_o    (frame_o),
  .frame_n_o  (frame_n_o),
  .ref_lost_o (ref_lost_o),
  .sel_edge   (sel_edge),
  .cnt        (cnt_q)
);

// File: tb/frame_timing_gen_test.sv
`timescale 1ns/1ps
module frame_timing_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       master_en_i = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic [2:0] ref_i = 3'd0;
  logic       frame_o, frame_n_o, ref_lost_o;

  int checks = 0, fails = 0;
  bit done = 0;
  string req = "R2";
  int per[3] = '{0, 0, 0};
  int off[3] = '{0, 0, 0};
  longint t = 0;
  longint last_fr = -1;
  int last_int = 0;
  bit band_chk = 0;

  always #5 clk_i = ~clk_i;

  frame_timing_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .master_en_i(master_en_i), .mode_i(mode_i),
    .ref_i(ref_i), .frame_o(frame_o), .frame_n_o(frame_n_o), .ref_lost_o(ref_lost_o)
  );

  // behavioural reference model
  int m_cnt, m_adj, m_miss;
  bit m_lost;
  bit h[3][3];

  function automatic bit is_act();
    return master_en_i && (mode_i[1:0] != 0);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_adj = 0; m_miss = 0; m_lost = 0;
      foreach (h[r, k]) h[r][k] = 0;
    end else begin
      bit act, ph, e, wrap;
      int sel, term;
      act = is_act();
      ph  = mode_i[2];
      sel = act ? int'(mode_i[1:0]) - 1 : 0;
      e   = act && h[sel][1] && !h[sel][2];
      for (int r = 0; r < 3; r++) begin
        h[r][2] = h[r][1]; h[r][1] = h[r][0]; h[r][0] = ref_i[r];
      end
      if (!act) begin
        m_cnt = 0; m_adj = 0; m_miss = 0; m_lost = 0;
      end else begin
        int c0;
        c0   = m_cnt;
        term = ph ? 2047 : 2047 + m_adj;
        wrap = (c0 >= term);
        m_cnt = ((ph && e) || wrap) ? 0 : c0 + 1;
        if (ph) m_adj = 0;
        else if (e) m_adj = (c0 == 0) ? 0 : (c0 < 1024 ? 1 : -1);
        else if (wrap) m_adj = 0;
        if (e) begin m_miss = 0; m_lost = 0; end
        else if (wrap) begin
          if (m_miss < 4) m_miss++;
          if (m_miss >= 4) m_lost = 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string r, string what, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0d", r, what, act_v, exp_v, t);
    end
  endtask

  // compare on every clock, away from the active edge, then drive next inputs
  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      begin
        bit ef;
        ef = is_act() && (m_cnt == 0);
        chk(frame_o == ef, req, "frame_o", frame_o, ef);
        chk(frame_n_o == !ef, "R3", "frame_n_o", frame_n_o, !ef);
        chk(ref_lost_o == (is_act() && m_lost), req, "ref_lost_o", ref_lost_o, is_act() && m_lost);
        if (frame_o) begin
          if (last_fr >= 0) begin
            last_int = int'(t - last_fr);
            if (band_chk)
              chk(last_int >= 2047 && last_int <= 2049, "R6", "frame interval", last_int, 2048);
          end
          last_fr = t;
        end
      end
      t++;
      for (int r = 0; r < 3; r++)
        ref_i[r] = (per[r] > 0) && (((t + off[r]) % per[r]) < 4);
    end
  endtask

  task automatic phase_start(string r, bit en, logic [2:0] m);
    req = r; master_en_i = en; mode_i = m; last_fr = -1; band_chk = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    #1;
    chk(frame_o == 0 && frame_n_o == 1 && ref_lost_o == 0, "R2", "reset outputs", frame_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: idle codes 0 and 4 with references toggling
    per = '{2000, 2048, 1900};
    phase_start("R2", 1, 3'd0); step(2500);
    phase_start("R2", 1, 3'd4); step(2500);

    // R3/R4/R5/R1: aligning on ref 0 with decoys at other periods
    phase_start("R5", 1, 3'd5);
    off = '{100, 0, 0};
    step(12000);
    chk(last_int == 2000, "R5", "aligned interval ref0", last_int, 2000);
    // R1: code 6 follows ref 1 (period 1900), not ref 0
    per = '{2000, 1900, 1800};
    phase_start("R1", 1, 3'd6); step(10000);
    chk(last_int == 1900, "R1", "aligned interval ref1", last_int, 1900);
    phase_start("R1", 1, 3'd7); step(10000);
    chk(last_int == 1800, "R1", "aligned interval ref2", last_int, 1800);

    // R4: single edge latency in aligning mode from a known count
    per = '{0, 0, 0};
    phase_start("R4", 1, 3'd5); step(700);
    ref_i[0] = 1'b1;           // first sampled at next rising edge k
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    chk(frame_o == 0, "R4", "no pulse before k+2", frame_o, 0);
    @(negedge clk_i);
    chk(frame_o == 1, "R4", "pulse after k+2", frame_o, 1);
    ref_i[0] = 1'b0;
    t += 3;
    step(100);

    // R3: freewheel period with no reference, nominal 2048
    phase_start("R3", 1, 3'd1); step(5000);
    chk(last_int == 2048, "R3", "nominal interval", last_int, 2048);

    // R6: tracking, edge early in frame (lengthen) then late (shorten)
    per = '{2048, 1700, 0}; off = '{2048 - 300, 0, 0};
    phase_start("R6", 1, 3'd1); step(50); band_chk = 1; step(25000);
    per = '{0, 0, 2048}; off = '{0, 0, 900};
    phase_start("R6", 1, 3'd3); step(50); band_chk = 1; step(25000);
    per = '{0, 0, 2047};
    band_chk = 1; step(12000);
    band_chk = 0;

    // R7: loss of reference and recovery
    per = '{0, 0, 0};
    phase_start("R7", 1, 3'd2); step(2048 * 3 + 100);
    chk(ref_lost_o == 0, "R7", "not lost after 3 wraps", ref_lost_o, 0);
    step(2048 * 2);
    chk(ref_lost_o == 1, "R7", "lost after 4 wraps", ref_lost_o, 1);
    step(2048 * 2);
    chk(last_int == 2048, "R7", "freewheel interval", last_int, 2048);
    per = '{0, 2048, 0}; off = '{0, 2040, 0};
    step(3000);
    chk(ref_lost_o == 0, "R7", "cleared by edge", ref_lost_o, 0);

    // R2: enable dropped mid-run
    phase_start("R2", 0, 3'd2); step(3000);
    chk(frame_o == 0 && frame_n_o == 1, "R2", "disabled outputs", frame_o, 0);
    phase_start("R2", 1, 3'd2); step(10);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule